// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two predictors run side by side. A global predictor indexes a table of 2-bit counters with the recent outcomes of all branches. A two-level local predictor first looks up a per-branch outcome history, chosen by fetch PC bits, and uses that history to select a 3-bit saturating counter. A table of 2-bit chooser counters, indexed by the same global history, picks which of the two predictions is delivered. The fetch stage presents a PC and gets all three predictions back in the same cycle through combinational logic.

When a branch resolves, the pipeline presents it on the update port. The port carries the branch PC, the actual outcome and the two component predictions that were made for it. In that one clock edge the block trains the global counter and the local counter, steers the chooser, shifts the outcome into the branch's local history entry, and shifts it into the global history. History is kept only at resolution and is never updated speculatively. With the default parameters the storage is 4096×2 global, 4096×2 chooser, 1024×10 local history and 1024×3 local counter bits.

Top module: `tournament_predictor`

## Requirements
- R1: While reset is asserted, every global counter is set to 1 (weakly not taken). Every local counter is set to 3 (weakly not taken). Every chooser counter is set to 1 (weakly prefer local). The global history and all local histories are set to zero. After reset, every prediction output is 0 for any PC.
- R2: `predGlobal` is the MSB of the 2-bit global counter selected by the global history. The history holds 1 for taken and 0 for not taken, and bit 0 is the most recent outcome.
- R3: The local history entry is selected by PC bits [LHT_IDX_W+1:2], and that history selects a local counter. `predLocal` is 1 exactly when the counter's value is 4 or more (its MSB is set).
- R4: `predTaken` equals `predGlobal` when the chooser counter selected by the global history is 2 or 3, and equals `predLocal` when it is 0 or 1.
- R5: On an update, the global counter at the current global history counts up on taken and down on not taken. It saturates at 0 and 3.
- R6: On an update, the local counter selected by the update PC's local history, read before that history shifts, counts up on taken and down on not taken. It saturates at 0 and 7.
- R7: On an update, the chooser counter at the current global history moves up by one when only the global prediction matched the outcome. It moves down by one when only the local prediction matched. It is unchanged when both matched or both missed, and it saturates at 0 and 3.
- R8: Each update shifts the global history left by one place and puts the actual outcome into bit 0.
- R9: Each update shifts the local history entry of the update PC left by one place, with the outcome in bit 0. Other local history entries are unchanged, and PCs that share index bits share the entry.
- R10: While the update valid input is low, no table or history changes, whatever the other update inputs carry.
- R11: The predictions follow the fetch PC combinationally. An update becomes visible in the predictions from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchPc | input | PC_W | PC to predict for |
| predTaken | output | 1 | Final prediction, 1 = taken |
| predGlobal | output | 1 | Global component prediction |
| predLocal | output | 1 | Local component prediction |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | PC of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |
| updGlobalPred | input | 1 | Global prediction made for that branch |
| updLocalPred | input | 1 | Local prediction made for that branch |

## Verification
The bench builds the block with a 4-bit global history, 8 local history entries and 4-bit local histories. At these sizes the global history fills after four updates and the same chooser and global entries are revisited again and again. Counters reach both saturation limits within a short stimulus table, and two test PCs alias onto one local history entry. The forced component predictions on the update port drive the chooser through its both-right, both-wrong, global-only and local-only cases, and through both of its limits.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

  // Strobes from the update control to the table datapath
  typedef struct packed {
    logic write;       // commit this resolved branch
    logic outcome;     // actual direction, 1 = taken
    logic chooseUp;    // only the global side was right
    logic chooseDown;  // only the local side was right
  } updStrobe_t;

endpackage

// File: rtl/tourn_update_ctrl.sv
module tourn_update_ctrl
  import tourn_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updGlobalPred,
  input  logic       updLocalPred,
  output updStrobe_t strobe
);

  logic globalRight;
  logic localRight;

  assign globalRight = (updGlobalPred == updTaken);
  assign localRight  = (updLocalPred == updTaken);

  always_comb begin
    strobe            = '0;
    strobe.write      = updValid;
    strobe.outcome    = updTaken;
    strobe.chooseUp   = updValid && globalRight && !localRight;
    strobe.chooseDown = updValid && localRight && !globalRight;
  end

endmodule

// File: rtl/tourn_tables.sv
module tourn_tables
  import tourn_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int LCTR_W    = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [PC_W-1:0] updPc,
  input  updStrobe_t      strobe,
  output logic            predGlobal,
  output logic            predLocal,
  output logic            predTaken
);

  localparam int G_ENT = 1 << GHIST_W;
  localparam int H_ENT = 1 << LHT_IDX_W;
  localparam int L_ENT = 1 << LHIST_W;
  localparam int IDX_LO = 2;
  localparam int IDX_HI = LHT_IDX_W + IDX_LO - 1;
  localparam logic [1:0] G_INIT = 2'd1;
  localparam logic [1:0] C_INIT = 2'd1;
  localparam logic [LCTR_W-1:0] L_INIT = {1'b0, {(LCTR_W-1){1'b1}}};

  logic [GHIST_W-1:0] ghr;
  logic [1:0]         gTbl  [G_ENT];
  logic [1:0]         chTbl [G_ENT];
  logic [LHIST_W-1:0] lhtTbl[H_ENT];
  logic [LCTR_W-1:0]  lTbl  [L_ENT];

  logic [LHT_IDX_W-1:0] fetchIdx;
  logic [LHT_IDX_W-1:0] updIdx;
  logic [LHIST_W-1:0]   fetchHist;
  logic [LHIST_W-1:0]   updHist;
  logic                 unusedPcBits;

  assign fetchIdx     = fetchPc[IDX_HI:IDX_LO];
  assign updIdx       = updPc[IDX_HI:IDX_LO];
  assign unusedPcBits = ^{fetchPc[PC_W-1:IDX_HI+1], fetchPc[IDX_LO-1:0],
                          updPc[PC_W-1:IDX_HI+1], updPc[IDX_LO-1:0]};

  // Lookup side
  assign fetchHist  = lhtTbl[fetchIdx];
  assign predGlobal = gTbl[ghr][1];
  assign predLocal  = lTbl[fetchHist][LCTR_W-1];
  assign predTaken  = chTbl[ghr][1] ? predGlobal : predLocal;

  assign updHist = lhtTbl[updIdx];

  function automatic logic [1:0] bump2(input logic [1:0] v, input logic up);
    if (up) return (v == 2'd3) ? v : v + 2'd1;
    else    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

  function automatic logic [LCTR_W-1:0] bumpL(input logic [LCTR_W-1:0] v, input logic up);
    if (up) return (v == '1) ? v : v + 1'b1;
    else    return (v == '0) ? v : v - 1'b1;
  endfunction

  // Training side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ghr <= '0;
      for (int i = 0; i < G_ENT; i++) begin
        gTbl[i]  <= G_INIT;
        chTbl[i] <= C_INIT;
      end
      for (int i = 0; i < H_ENT; i++) lhtTbl[i] <= '0;
      for (int i = 0; i < L_ENT; i++) lTbl[i] <= L_INIT;
    end else if (strobe.write) begin
      ghr            <= {ghr[GHIST_W-2:0], strobe.outcome};
      gTbl[ghr]      <= bump2(gTbl[ghr], strobe.outcome);
      if (strobe.chooseUp)
        chTbl[ghr]   <= bump2(chTbl[ghr], 1'b1);
      else if (strobe.chooseDown)
        chTbl[ghr]   <= bump2(chTbl[ghr], 1'b0);
      lhtTbl[updIdx] <= {updHist[LHIST_W-2:0], strobe.outcome};
      lTbl[updHist]  <= bumpL(lTbl[updHist], strobe.outcome);
    end
  end

  // Checks next to the state they guard
  AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write |=> ghr == {$past(ghr[GHIST_W-2:0]), $past(strobe.outcome)}); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.write |=> $stable(ghr)); // R10

  AST_CHOICE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write && !strobe.chooseUp && !strobe.chooseDown
      |=> chTbl[$past(ghr)] == $past(chTbl[ghr])); // R7

  AST_GCTR_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write && strobe.outcome && gTbl[ghr] == 2'd3
      |=> gTbl[$past(ghr)] == 2'd3); // R5

  AST_LCTR_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write && !strobe.outcome && lTbl[updHist] == '0
      |=> lTbl[$past(updHist)] == '0); // R6

  AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write |=> lhtTbl[$past(updIdx)] ==
      {$past(updHist[LHIST_W-2:0]), $past(strobe.outcome)}); // R9

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
  import tourn_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int LCTR_W    = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predTaken,
  output logic            predGlobal,
  output logic            predLocal,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic            updGlobalPred,
  input  logic            updLocalPred
);

  updStrobe_t strobe;

  tourn_update_ctrl uCtrl (
    .updValid      (updValid),
    .updTaken      (updTaken),
    .updGlobalPred (updGlobalPred),
    .updLocalPred  (updLocalPred),
    .strobe        (strobe)
  );

  tourn_tables #(
    .PC_W      (PC_W),
    .GHIST_W   (GHIST_W),
    .LHT_IDX_W (LHT_IDX_W),
    .LHIST_W   (LHIST_W),
    .LCTR_W    (LCTR_W)
  ) uTables (
    .clk        (clk),
    .rstN       (rstN),
    .fetchPc    (fetchPc),
    .updPc      (updPc),
    .strobe     (strobe),
    .predGlobal (predGlobal),
    .predLocal  (predLocal),
    .predTaken  (predTaken)
  );

  AST_FINAL_FROM_PARTS: assert property (@(posedge clk) disable iff (!rstN)
    predTaken == predGlobal || predTaken == predLocal); // R4

endmodule

// File: tb/tb_tournament_predictor.sv
module tb_tournament_predictor;

  localparam int PC_W = 32;
  localparam int GW   = 4;
  localparam int LIW  = 3;
  localparam int LHW  = 4;
  localparam int LCW  = 3;
  localparam int NVEC = 24;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] fetchPc = '0;
  logic            predTaken, predGlobal, predLocal;
  logic            updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic            updTaken = 1'b0;
  logic            updGlobalPred = 1'b0;
  logic            updLocalPred = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tournament_predictor #(
    .PC_W(PC_W), .GHIST_W(GW), .LHT_IDX_W(LIW), .LHIST_W(LHW), .LCTR_W(LCW)
  ) dut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc),
    .predTaken(predTaken), .predGlobal(predGlobal), .predLocal(predLocal),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updGlobalPred(updGlobalPred), .updLocalPred(updLocalPred)
  );

  // Stimulus vectors {pc, taken}; 0x40 and 0x60 share local index 0
  localparam logic [16:0] VEC [NVEC] = '{
    {16'h0040, 1'b1}, {16'h0084, 1'b1}, {16'h001C, 1'b1}, {16'h0040, 1'b1},
    {16'h0084, 1'b0}, {16'h001C, 1'b1}, {16'h0040, 1'b1}, {16'h0060, 1'b0},
    {16'h0084, 1'b1}, {16'h0040, 1'b0}, {16'h001C, 1'b1}, {16'h0084, 1'b0},
    {16'h0040, 1'b1}, {16'h0060, 1'b0}, {16'h001C, 1'b1}, {16'h0084, 1'b1},
    {16'h0040, 1'b1}, {16'h0040, 1'b1}, {16'h0084, 1'b0}, {16'h0060, 1'b1},
    {16'h001C, 1'b0}, {16'h0040, 1'b0}, {16'h0084, 1'b1}, {16'h001C, 1'b1}
  };

  // Expected-state model built from the requirements
  logic [1:0]     mG  [1<<GW];
  logic [1:0]     mC  [1<<GW];
  logic [LHW-1:0] mLh [1<<LIW];
  logic [LCW-1:0] mL  [1<<LHW];
  logic [GW-1:0]  mGhr;

  task automatic modelReset();
    for (int i = 0; i < (1<<GW); i++) begin mG[i] = 2'd1; mC[i] = 2'd1; end
    for (int i = 0; i < (1<<LIW); i++) mLh[i] = '0;
    for (int i = 0; i < (1<<LHW); i++) mL[i] = 3'd3;
    mGhr = '0;
  endtask

  function automatic logic [2:0] modelPred(input logic [PC_W-1:0] pc);
    logic g, l;
    g = mG[mGhr] >= 2'd2;
    l = mL[mLh[pc[LIW+1:2]]] >= 3'd4;
    return {(mC[mGhr] >= 2'd2) ? g : l, g, l};
  endfunction

  task automatic modelUpdate(input logic [PC_W-1:0] pc, input logic t,
                             input logic g, input logic l);
    logic [LHW-1:0] h;
    h = mLh[pc[LIW+1:2]];
    if (t) begin
      if (mG[mGhr] != 2'd3) mG[mGhr] = mG[mGhr] + 2'd1;
      if (mL[h] != 3'd7) mL[h] = mL[h] + 3'd1;
    end else begin
      if (mG[mGhr] != 2'd0) mG[mGhr] = mG[mGhr] - 2'd1;
      if (mL[h] != 3'd0) mL[h] = mL[h] - 3'd1;
    end
    if (g == t && l != t && mC[mGhr] != 2'd3) mC[mGhr] = mC[mGhr] + 2'd1;
    if (l == t && g != t && mC[mGhr] != 2'd0) mC[mGhr] = mC[mGhr] - 2'd1;
    mLh[pc[LIW+1:2]] = {h[LHW-2:0], t};
    mGhr = {mGhr[GW-2:0], t};
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Compare all three outputs for one PC against the model (R2 R3 R4)
  task automatic checkPc(input string req, input logic [PC_W-1:0] pc);
    logic [2:0] e;
    fetchPc = pc;
    #1;
    e = modelPred(pc);
    chk(req, "predGlobal R2", predGlobal, e[1]);
    chk(req, "predLocal R3", predLocal, e[0]);
    chk(req, "predTaken R4", predTaken, e[2]);
  endtask

  // One predict-then-resolve step; forced component predictions when frc set
  task automatic step(input string req, input logic [PC_W-1:0] pc, input logic t,
                      input bit frc, input logic fg, input logic fl);
    logic [2:0] e;
    @(negedge clk);
    updValid = 1'b0;
    checkPc(req, pc);
    e = modelPred(pc);
    updPc = pc;
    updTaken = t;
    updGlobalPred = frc ? fg : e[1];
    updLocalPred  = frc ? fl : e[0];
    updValid = 1'b1;
    @(posedge clk);
    modelUpdate(pc, t, updGlobalPred, updLocalPred);
  endtask

  task automatic doReset();
    @(negedge clk);
    updValid = 1'b0;
    rstN = 1'b0;
    modelReset();
    @(negedge clk);
    // R1: reset state visible while reset is held
    for (int i = 0; i < (1<<LIW); i++) begin
      fetchPc = PC_W'(i * 4);
      #1;
      chk("R1", "predTaken", predTaken, 1'b0);
      chk("R1", "predGlobal", predGlobal, 1'b0);
      chk("R1", "predLocal", predLocal, 1'b0);
    end
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    doReset();

    // Main table walk: R2 R3 R4 R5 R6 R8 R9 R11
    for (int rep = 0; rep < 4; rep++)
      for (int v = 0; v < NVEC; v++)
        step("R11", PC_W'(VEC[v][16:1]), VEC[v][0], 1'b0, 1'b0, 1'b0);

    // R10: update inputs toggle without valid; nothing may move
    @(negedge clk);
    updValid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      updPc = PC_W'(k * 4);
      updTaken = k[0];
      updGlobalPred = k[1];
      updLocalPred = ~k[0];
      @(negedge clk);
    end
    for (int i = 0; i < (1<<LIW); i++) checkPc("R10", PC_W'(i * 4));

    // R7: chooser cases with forced component predictions from fresh state
    doReset();
    for (int k = 0; k < 6; k++) step("R7 global-only", 32'h40, 1'b1, 1'b1, 1'b1, 1'b0);
    checkPc("R7 ceiling", 32'h40);
    for (int k = 0; k < 3; k++) step("R7 both-wrong", 32'h40, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) step("R7 both-right", 32'h40, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 5; k++) step("R7 local-only", 32'h40, 1'b1, 1'b1, 1'b0, 1'b1);
    checkPc("R7 floor", 32'h40);

    // R5 R6: drive counters down to floor then up to ceiling
    for (int k = 0; k < 10; k++) step("R6 floor", 32'h1C, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) step("R5 ceiling", 32'h1C, 1'b1, 1'b0, 1'b0, 1'b0);
    checkPc("R6", 32'h1C);

    // R9: aliasing PCs share a history entry; another entry stays intact
    step("R9", 32'h60, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R9", 32'h40, 1'b1, 1'b0, 1'b0, 1'b0);
    checkPc("R9 neighbour", 32'h84);
    checkPc("R9 alias", 32'h60);

    @(negedge clk);
    updValid = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule